// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the built-in self-test of a dot-matrix character display controller. Writing 1 to the start bit of the control word gives it a one-cycle start pulse. It then stays busy for a fixed number of clocks, and during that time the rest of the controller must not be accessed. The test has three phases:

- **Checksum phase.** The block walks an address through every entry of the character decoder ROM and adds up the glyph data it reads back. It then compares the sum with a constant given as a parameter.
- **Checker phase.** It drives a checkerboard onto the dot matrix through a pattern-override port.
- **Inverse phase.** It drives the inverse checkerboard. The two pattern phases share equally the clocks left after the checksum phase.

When the run ends, the block gives a single cleanup pulse. On that pulse the register file loads the values the block presents: blank characters, a cleared flash memory, an all-ones user-glyph address, and a control word that is zero except for the pass bit.

The ROM sits outside the block. Its read is combinational: data for `rom_addr_o` is expected on `rom_data_i` in the same cycle. Row r of a glyph occupies bits [5r+4:5r]. The refresh logic provides the parity of the row it is scanning, and the block returns the override dots for every digit and column of that row.

Top module: `selftest_seq`

## Requirements
- R1: After reset, busy_o, pass_o, end_o and pat_en_o are 0 and pat_dots_o is all zeros.
- R2: A start_i pulse while idle raises busy_o from the next clock edge. busy_o then stays high for exactly TEST_CYCLES cycles (busy cycles numbered 0 to TEST_CYCLES-1).
- R3: In busy cycle k, for k < ROM_DEPTH, rom_addr_o equals k.
- R4: The checksum is the sum, modulo 2^SUM_W, of the seven 5-bit row words of every ROM entry, where row r is bits [5r+4:5r].
  - pass_o is cleared when a run starts.
  - From busy cycle ROM_DEPTH+1 onward, pass_o is 1 exactly when the checksum equals EXP_SUM.
  - pass_o holds its value while idle.
- R5: In busy cycles ROM_DEPTH to ROM_DEPTH+H-1, where H=(TEST_CYCLES-ROM_DEPTH)/2:
  - pat_en_o is 1 and pat_inv_o is 0.
  - Dot pat_dots_o[d*5+c] equals row_odd_i XOR c[0] XOR d[0].
- R6: In the last H busy cycles, pat_en_o and pat_inv_o are both 1, and every dot is the inverse of the R5 value.
- R7: The cycle after the last busy cycle, end_o is 1 for exactly one cycle, with:
  - ctrl_word_o equal to pass_o at bit 5 and zero in all other bits;
  - char_fill_o equal to 8'h20;
  - udc_fill_o all ones.
- R8: A start_i pulse while busy_o is 1 is ignored: it does not restart or lengthen the run, and it does not clear pass_o.
- R9: Whenever pat_en_o is 0, which includes the checksum phase and idle, pat_dots_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Self-test start pulse (control bit 6 written as 1) |
| rom_addr_o | output | ROM_AW | Decoder ROM address |
| rom_data_i | input | ROWS*COLS | Glyph data for rom_addr_o, row r in bits [5r+4:5r] |
| row_odd_i | input | 1 | Parity of the row currently being scanned |
| busy_o | output | 1 | Test running; the display must not be accessed |
| pass_o | output | 1 | Checksum matched (control bit 5) |
| pat_en_o | output | 1 | Pattern override active |
| pat_inv_o | output | 1 | Inverse checkerboard selected |
| pat_dots_o | output | DIGITS*COLS | Override dots for the scanned row, index d*COLS+c |
| end_o | output | 1 | One-cycle cleanup strobe |
| ctrl_word_o | output | REG_W | Control word to load on end_o |
| char_fill_o | output | 8 | Code to fill every character entry with on end_o |
| udc_fill_o | output | UDC_W | Value for the user-glyph address register on end_o |

## Verification
The bench counts falling edges from the edge that accepts the start pulse, so the sample at offset k sees busy cycle k.
- rom_addr_o and the pattern outputs depend combinationally on the cycle count, so they are checked at the same offset.
- pass_o passes through one register after the final accumulation, so it is first checked at offset ROM_DEPTH+1.
- end_o is due at offset TEST_CYCLES, and its low value is checked one offset later.

A vector table lists the phase boundaries at their exact offsets. Directed runs then cover a corrupted ROM and a start pulse sent in the middle of a run.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SUM  = 2'd1,
      PH_CHK  = 2'd2,
      PH_INV  = 2'd3
   } st_phase_e;

   localparam logic [7:0] BLANK_CHAR = 8'h20;
   localparam int         PASS_BIT   = 5;

endpackage

// File: rtl/selftest_ctrl.sv
module selftest_ctrl
   import selftest_pkg::*;
#(
   parameter int ROM_DEPTH   = 128,
   parameter int TEST_CYCLES = 262144,
   parameter int CNT_W       = $clog2(TEST_CYCLES + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic             begin_o,
   output logic             busy_o,
   output st_phase_e        phase_o,
   output logic [CNT_W-1:0] idx_o,
   output logic             sum_done_o,
   output logic             end_o
);
   localparam int               HALF    = (TEST_CYCLES - ROM_DEPTH) / 2;
   localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(TEST_CYCLES - 1);
   localparam logic [CNT_W-1:0] SUM_END = CNT_W'(ROM_DEPTH);
   localparam logic [CNT_W-1:0] CHK_END = CNT_W'(ROM_DEPTH + HALF);

   logic             busy_q, end_q;
   logic [CNT_W-1:0] cnt_q;

   assign begin_o = start_i & ~busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         end_q  <= 1'b0;
      end else begin
         end_q <= 1'b0;
         if (begin_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (cnt_q == LAST_C) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
               end_q  <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      if (!busy_q)                phase_o = PH_IDLE;
      else if (cnt_q < SUM_END)   phase_o = PH_SUM;
      else if (cnt_q < CHK_END)   phase_o = PH_CHK;
      else                        phase_o = PH_INV;
   end

   assign busy_o     = busy_q;
   assign idx_o      = cnt_q;
   assign sum_done_o = busy_q && (cnt_q == SUM_END);
   assign end_o      = end_q;

endmodule

// File: rtl/selftest_sum.sv
module selftest_sum #(
   parameter int ROWS    = 7,
   parameter int COLS    = 5,
   parameter int SUM_W   = 16,
   parameter bit BY_ROWS = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 clear_i,
   input  logic                 acc_i,
   input  logic [ROWS*COLS-1:0] glyph_i,
   output logic [SUM_W-1:0]     sum_o
);
   logic [SUM_W-1:0] part;
   logic [SUM_W-1:0] sum_q;

   generate
      if (BY_ROWS) begin : g_rows
         always_comb begin
            part = '0;
            for (int r = 0; r < ROWS; r++)
               part = part + SUM_W'(glyph_i[r*COLS +: COLS]);
         end
      end else begin : g_cols
         logic [ROWS-1:0] col_w;
         always_comb begin
            part  = '0;
            col_w = '0;
            for (int c = 0; c < COLS; c++) begin
               for (int r = 0; r < ROWS; r++)
                  col_w[r] = glyph_i[r*COLS + c];
               part = part + SUM_W'(col_w);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sum_q <= '0;
      else if (clear_i) sum_q <= '0;
      else if (acc_i)   sum_q <= sum_q + part;
   end

   assign sum_o = sum_q;

endmodule

// File: rtl/selftest_pattern.sv
module selftest_pattern #(
   parameter int DIGITS = 8,
   parameter int COLS   = 5
) (
   input  logic                   en_i,
   input  logic                   inv_i,
   input  logic                   row_odd_i,
   output logic [DIGITS*COLS-1:0] dots_o
);
   generate
      for (genvar d = 0; d < DIGITS; d++) begin : g_dig
         for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam logic PAR = 1'((c + d) % 2);
            assign dots_o[d*COLS + c] = en_i & (row_odd_i ^ PAR ^ inv_i);
         end
      end
   endgenerate

endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
   import selftest_pkg::*;
#(
   parameter int             ROM_DEPTH   = 128,
   parameter int             TEST_CYCLES = 262144,
   parameter int             ROWS        = 7,
   parameter int             COLS        = 5,
   parameter int             DIGITS      = 8,
   parameter int             SUM_W       = 16,
   parameter logic [15:0]    EXP_SUM     = 16'h0000,
   parameter bit             SUM_BY_ROWS = 1'b1,
   parameter int             REG_W       = 8,
   parameter int             UDC_W       = 8,
   parameter int             ROM_AW      = $clog2(ROM_DEPTH)
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   start_i,
   output logic [ROM_AW-1:0]      rom_addr_o,
   input  logic [ROWS*COLS-1:0]   rom_data_i,
   input  logic                   row_odd_i,
   output logic                   busy_o,
   output logic                   pass_o,
   output logic                   pat_en_o,
   output logic                   pat_inv_o,
   output logic [DIGITS*COLS-1:0] pat_dots_o,
   output logic                   end_o,
   output logic [REG_W-1:0]       ctrl_word_o,
   output logic [7:0]             char_fill_o,
   output logic [UDC_W-1:0]       udc_fill_o
);
   localparam int CNT_W = $clog2(TEST_CYCLES + 1);

   initial begin
      assert (TEST_CYCLES > ROM_DEPTH + 1)
         else $error("TEST_CYCLES must exceed ROM_DEPTH+1");
      assert (((TEST_CYCLES - ROM_DEPTH) % 2) == 0)
         else $error("pattern phases need an even remainder");
      assert (ROM_DEPTH == (1 << ROM_AW))
         else $error("ROM_DEPTH must be a power of two");
      assert (REG_W > PASS_BIT)
         else $error("REG_W too small for the pass bit");
      assert (SUM_W <= 16)
         else $error("SUM_W wider than EXP_SUM");
   end

   st_phase_e        phase;
   logic [CNT_W-1:0] idx;
   logic             begin_w, sum_done;
   logic [SUM_W-1:0] sum;
   logic             pass_q;

   selftest_ctrl #(
      .ROM_DEPTH   (ROM_DEPTH),
      .TEST_CYCLES (TEST_CYCLES),
      .CNT_W       (CNT_W)
   ) i_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .begin_o    (begin_w),
      .busy_o     (busy_o),
      .phase_o    (phase),
      .idx_o      (idx),
      .sum_done_o (sum_done),
      .end_o      (end_o)
   );

   selftest_sum #(
      .ROWS    (ROWS),
      .COLS    (COLS),
      .SUM_W   (SUM_W),
      .BY_ROWS (SUM_BY_ROWS)
   ) i_sum (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (begin_w),
      .acc_i   (phase == PH_SUM),
      .glyph_i (rom_data_i),
      .sum_o   (sum)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pass_q <= 1'b0;
      else if (begin_w)  pass_q <= 1'b0;
      else if (sum_done) pass_q <= (sum == EXP_SUM[SUM_W-1:0]);
   end

   assign rom_addr_o = (phase == PH_SUM) ? idx[ROM_AW-1:0] : '0;
   assign pat_en_o   = (phase == PH_CHK) || (phase == PH_INV);
   assign pat_inv_o  = (phase == PH_INV);
   assign pass_o     = pass_q;

   selftest_pattern #(
      .DIGITS (DIGITS),
      .COLS   (COLS)
   ) i_pat (
      .en_i      (pat_en_o),
      .inv_i     (pat_inv_o),
      .row_odd_i (row_odd_i),
      .dots_o    (pat_dots_o)
   );

   always_comb begin
      ctrl_word_o           = '0;
      ctrl_word_o[PASS_BIT] = pass_q;
   end
   assign char_fill_o = BLANK_CHAR;
   assign udc_fill_o  = '1;

endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk #(
   parameter int ROM_DEPTH   = 128,
   parameter int TEST_CYCLES = 262144,
   parameter int ROM_AW      = 7,
   parameter int DOTS        = 40,
   parameter int REG_W       = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic              busy_o,
   input logic              pass_o,
   input logic              pat_en_o,
   input logic              pat_inv_o,
   input logic [DOTS-1:0]   pat_dots_o,
   input logic              end_o,
   input logic [ROM_AW-1:0] rom_addr_o,
   input logic [REG_W-1:0]  ctrl_word_o
);
   localparam int HALF = (TEST_CYCLES - ROM_DEPTH) / 2;

   logic [31:0] run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     run_q <= '0;
      else if (busy_o) run_q <= run_q + 1;
      else             run_q <= '0;
   end

   // R1
   idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !$past(busy_o)) |-> (!end_o && !pat_en_o));

   // R2
   start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && start_i) |=> busy_o);

   // R2
   run_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (run_q < TEST_CYCLES));

   // R3
   rom_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && run_q < ROM_DEPTH) |-> (rom_addr_o == ROM_AW'(run_q)));

   // R4
   pass_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(busy_o && (run_q == 0 || run_q == ROM_DEPTH + 1)) |-> $stable(pass_o));

   // R5
   pattern_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pat_en_o |-> (busy_o && run_q >= ROM_DEPTH));

   // R6
   inverse_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pat_inv_o |-> (pat_en_o && run_q >= ROM_DEPTH + HALF));

   // R7
   end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      end_o |=> !end_o);

   // R7
   end_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> (end_o && ctrl_word_o[5] == pass_o &&
                         $countones(ctrl_word_o) == 32'(pass_o)));

   // R8
   busy_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i && run_q < TEST_CYCLES - 1) |=> busy_o);

   // R9
   dots_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pat_en_o |-> (pat_dots_o == '0));

endmodule

bind selftest_seq selftest_seq_chk #(
   .ROM_DEPTH   (ROM_DEPTH),
   .TEST_CYCLES (TEST_CYCLES),
   .ROM_AW      (ROM_AW),
   .DOTS        (DIGITS*COLS),
   .REG_W       (REG_W)
) i_selftest_seq_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .pass_o      (pass_o),
   .pat_en_o    (pat_en_o),
   .pat_inv_o   (pat_inv_o),
   .pat_dots_o  (pat_dots_o),
   .end_o       (end_o),
   .rom_addr_o  (rom_addr_o),
   .ctrl_word_o (ctrl_word_o)
);

// File: tb/test_selftest_seq.sv
`timescale 1ns/1ps
module test_selftest_seq;
   localparam int D  = 16;
   localparam int T  = 80;
   localparam int H  = (T - D) / 2;
   localparam int AW = 4;

   function automatic logic [34:0] glyph(int a);
      logic [31:0] h;
      h = 32'(a) * 32'h9E3779B1;
      return {3'(a), h};
   endfunction

   function automatic logic [15:0] golden_sum();
      logic [15:0] s;
      s = '0;
      for (int a = 0; a < D; a++) begin
         logic [34:0] g;
         g = glyph(a);
         for (int r = 0; r < 7; r++) s = s + 16'(g[r*5 +: 5]);
      end
      return s;
   endfunction

   localparam logic [15:0] GOLD = golden_sum();

   // offset, busy, pat_en, pat_inv, end
   typedef struct packed {
      logic [7:0] off;
      logic [3:0] flags;
   } vec_t;
   localparam vec_t VECS [8] = '{
      '{8'd0,  4'b1000}, '{8'd15, 4'b1000}, '{8'd16, 4'b1100}, '{8'd47, 4'b1100},
      '{8'd48, 4'b1110}, '{8'd79, 4'b1110}, '{8'd80, 4'b0001}, '{8'd81, 4'b0000}};

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, row_odd = 1'b0, corrupt = 1'b0;
   logic [AW-1:0] rom_addr;
   logic [34:0]   rom_data;
   logic busy, pass, pat_en, pat_inv, endp;
   logic [39:0] dots;
   logic [7:0]  ctrl_word, char_fill, udc_fill;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   always_comb rom_data = glyph(int'(rom_addr)) ^ ((corrupt && rom_addr == 4'd3) ? 35'h1 : 35'h0);

   selftest_seq #(
      .ROM_DEPTH(D), .TEST_CYCLES(T), .EXP_SUM(GOLD)
   ) i_selftest_seq (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .rom_addr_o(rom_addr), .rom_data_i(rom_data), .row_odd_i(row_odd),
      .busy_o(busy), .pass_o(pass), .pat_en_o(pat_en), .pat_inv_o(pat_inv),
      .pat_dots_o(dots), .end_o(endp), .ctrl_word_o(ctrl_word),
      .char_fill_o(char_fill), .udc_fill_o(udc_fill)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [39:0] exp_dots(logic odd, logic inv);
      logic [39:0] v;
      for (int d = 0; d < 8; d++)
         for (int c = 0; c < 5; c++)
            v[d*5 + c] = odd ^ 1'(c) ^ 1'(d) ^ inv;
      return v;
   endfunction

   task automatic run(bit bad, bit poke);
      logic exp_pass;
      exp_pass = !bad;
      corrupt  = bad;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i <= T + 1; i++) begin
         foreach (VECS[v])
            if (int'(VECS[v].off) == i)
               chk($sformatf("R2 vector at offset %0d", i),
                   {busy, pat_en, pat_inv, endp}, VECS[v].flags);
         if (i == 0) chk("R4 pass cleared at start", pass, 0);
         if (i == 5) chk("R3 rom address", rom_addr, 5);
         if (i == D - 1) chk("R3 last rom address", rom_addr, D - 1);
         if (i == 8) chk("R9 dots quiet in checksum phase", dots, 0);
         if (i == D + 1) chk("R4 pass result", pass, exp_pass);
         if (i == 20) begin row_odd = 1'b0; #1 chk("R5 checker row even", dots, exp_dots(0, 0)); end
         if (i == 30) begin row_odd = 1'b1; #1 chk("R5 checker row odd", dots, exp_dots(1, 0)); end
         if (i == 60) begin row_odd = 1'b1; #1 chk("R6 inverse row odd", dots, exp_dots(1, 1)); end
         if (i == 70) begin row_odd = 1'b0; #1 chk("R6 inverse row even", dots, exp_dots(0, 1)); end
         if (i == T) begin
            chk("R7 control word", ctrl_word, exp_pass ? 8'h20 : 8'h00);
            chk("R7 char fill", char_fill, 8'h20);
            chk("R7 udc fill", udc_fill, 8'hFF);
            if (poke) chk("R8 run length kept after restart", endp, 1);
         end
         if (i == T + 1) chk("R9 dots quiet when idle", dots, 0);
         if (poke && (i == 40 || i == 17)) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy at reset", busy, 0);
      chk("R1 pass at reset", pass, 0);
      chk("R1 end at reset", endp, 0);
      chk("R1 dots at reset", {pat_en, dots}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run(0, 0);
      repeat (5) @(negedge clk);
      chk("R4 pass held while idle", pass, 1);
      run(1, 1);
      chk("R8 pass not cleared by late start", pass, 0);
      run(0, 1);
      chk("R4 pass after clean rerun", pass, 1);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule